// File: doc/BRIEF.md
# Serial Register Bank Interface Configuration and Double-Buffer Control

This block holds the interface configuration registers of a serial register bank and the double-buffering logic for the one configuration register that is staged before it takes effect. A host reaches it through a single-cycle register port. A write is a one-cycle strobe with an address and a data byte. A read is combinational: the data for the presented address appears on the read bus in the same cycle.

A small state machine orders the self-clearing actions. It has three states, `ST_RUN`, `ST_SRST` and `ST_COMMIT`, and these transitions:

- `ST_RUN` or `ST_COMMIT` goes to `ST_SRST` on a soft-reset request.
- `ST_RUN` or `ST_COMMIT` goes to `ST_COMMIT` on an update request when no soft reset is requested.
- `ST_RUN` or `ST_COMMIT` goes to `ST_RUN` otherwise.
- `ST_SRST` always returns to `ST_RUN`.

While in `ST_SRST`, the block drives a one-cycle soft-reset pulse to the rest of the bank and clears the staged register. It leaves the interface configuration untouched. While in `ST_COMMIT`, it copies the buffer copy of the staged register into the active copy.

Register map, with byte-wide data:

| Address | Contents |
|---|---|
| 0x0000 | Bit 7 is the soft-reset request. Bits 6:4 are fixed at 0,0,1. Bits 3:0 mirror bits 4..7 in reverse order. |
| 0x0001 | Bit 5 is the readback select. |
| 0x000F | Bit 0 is the update request. |
| 0x0100 | The staged register. |

Top module: `ifc_cfg_bank`

## Requirements
- R1: After the reset input is released, 0x0000 reads 0x18, while 0x0001, 0x000F and 0x0100 read 0x00, and the soft-reset output is low.
- R2: A write to 0x0000 with bit 7 set raises the soft-reset output for exactly the one cycle after the write edge. In that cycle 0x0000 reads 0x99, and afterwards it reads 0x18 again.
- R3: Bits 6:4 of 0x0000 always read 0,0,1 whatever is written. Bits 3:0 always read bit 4, bit 5, bit 6 and bit 7 in that order (bit 3 equals bit 4, and bit 0 equals bit 7). A written low nibble that breaks the mirror is accepted but has no effect on the readback.
- R4: Bit 5 of 0x0001 is writable, and all other bits of 0x0001 read 0.
- R5: A soft reset leaves bit 5 of 0x0001 unchanged. A write to 0x0001 made in the soft-reset cycle still takes effect.
- R6: Writes to 0x0100 land in the buffer copy. The active copy does not change until an update.
- R7: A write to 0x000F with bit 0 set makes 0x000F read 0x01 for the next cycle only. At the end of that cycle the active copy takes the value the buffer copy holds at that moment.
- R8: 0x0100 reads the active copy when bit 5 of 0x0001 is 0, and the buffer copy when that bit is 1.
- R9: A soft reset clears both copies of 0x0100 and any update in progress at the end of the pulse cycle.
- R10: Bits 7:1 of 0x000F read 0. A write to 0x000F with bit 0 clear starts no update.
- R11: Any address outside the four mapped ones reads 0x00.
- R12: In the soft-reset cycle, writes to 0x0100, to 0x000F and to bit 7 of 0x0000 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Register address for both write and read |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse to the rest of the bank |

## Verification
Read data is combinational, so a register's value is due in the cycle after the edge that stores it. The soft-reset pulse and the update flag are both visible in the cycle that follows the write edge. The copy into the active register is visible one cycle later again, that is two edges after the update write. The bench drives at the falling edge, samples just before the next rising edge against a behavioural model, and advances that model only after the rising edge, so each comparison sees exactly the registers that edge has produced.

// File: rtl/ifc_cfg_pkg.sv
package ifc_cfg_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_SRST   = 2'd1,
        ST_COMMIT = 2'd2
    } ifc_state_e;

    localparam int SRST_BIT   = 7;   // request bit in the first configuration register
    localparam int SEL_BIT    = 5;   // readback select in the second configuration register
    localparam int UPD_BIT    = 0;   // update request bit
    localparam int NIB_W      = 4;
    localparam logic [2:0] FIXED_BITS = 3'b001; // bits 6:4 of the first register
endpackage

// File: rtl/ifc_cfg_fsm.sv
module ifc_cfg_fsm
    import ifc_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst_req,
    input  logic commit_req,
    output logic soft_rst_o,
    output logic commit_o
);
    ifc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN, ST_COMMIT: begin
                if (srst_req)        state_d = ST_SRST;
                else if (commit_req) state_d = ST_COMMIT;
                else                 state_d = ST_RUN;
            end
            ST_SRST: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        soft_rst_o = 1'b0;
        commit_o   = 1'b0;
        unique case (state_q)
            ST_SRST:   soft_rst_o = 1'b1;
            ST_COMMIT: commit_o   = 1'b1;
            default: begin
                soft_rst_o = 1'b0;
                commit_o   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ifc_dbuf_reg.sv
module ifc_dbuf_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic         commit,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            act_q <= '0;
        end else if (clr) begin
            buf_q <= '0;
            act_q <= '0;
        end else begin
            if (commit) act_q <= buf_q;
            if (wr_en)  buf_q <= wdata;
        end
    end
endmodule

// File: rtl/ifc_rd_mux.sv
module ifc_rd_mux
    import ifc_cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADR_CFGA = 'h0000,
    parameter logic [ADDR_W-1:0] ADR_CFGB = 'h0001,
    parameter logic [ADDR_W-1:0] ADR_UPD  = 'h000F,
    parameter logic [ADDR_W-1:0] ADR_BUF  = 'h0100
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              srst_flag,
    input  logic              sel,
    input  logic              commit,
    input  logic [DATA_W-1:0] buf_q,
    input  logic [DATA_W-1:0] act_q,
    output logic [DATA_W-1:0] rdata
);
    logic [NIB_W-1:0] hi_nib;
    logic [NIB_W-1:0] lo_nib;
    logic [DATA_W-1:0] cfga_word;
    logic [DATA_W-1:0] cfgb_word;
    logic [DATA_W-1:0] upd_word;

    assign hi_nib = {srst_flag, FIXED_BITS};

    for (genvar g = 0; g < NIB_W; g++) begin : g_mirror
        assign lo_nib[g] = hi_nib[NIB_W-1-g];
    end

    always_comb begin
        cfga_word = '0;
        cfga_word[2*NIB_W-1:0] = {hi_nib, lo_nib};
        cfgb_word = '0;
        cfgb_word[SEL_BIT] = sel;
        upd_word = '0;
        upd_word[UPD_BIT] = commit;
    end

    always_comb begin
        if (reg_addr == ADR_CFGA)      rdata = cfga_word;
        else if (reg_addr == ADR_CFGB) rdata = cfgb_word;
        else if (reg_addr == ADR_UPD)  rdata = upd_word;
        else if (reg_addr == ADR_BUF)  rdata = sel ? buf_q : act_q;
        else                           rdata = '0;
    end
endmodule

// File: rtl/ifc_cfg_bank.sv
module ifc_cfg_bank
    import ifc_cfg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADR_CFGA = 'h0000,
    parameter logic [ADDR_W-1:0] ADR_CFGB = 'h0001,
    parameter logic [ADDR_W-1:0] ADR_UPD  = 'h000F,
    parameter logic [ADDR_W-1:0] ADR_BUF  = 'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              soft_rst_o
);
    logic hit_cfga, hit_cfgb, hit_upd, hit_buf;
    logic srst_req, commit_req, buf_wr;
    logic commit;
    logic sel_q;
    logic [DATA_W-1:0] buf_q, act_q;

    assign hit_cfga = reg_wr && (reg_addr == ADR_CFGA);
    assign hit_cfgb = reg_wr && (reg_addr == ADR_CFGB);
    assign hit_upd  = reg_wr && (reg_addr == ADR_UPD);
    assign hit_buf  = reg_wr && (reg_addr == ADR_BUF);

    assign srst_req   = hit_cfga && reg_wdata[SRST_BIT];
    assign commit_req = hit_upd && reg_wdata[UPD_BIT];
    assign buf_wr     = hit_buf && !soft_rst_o;

    // readback select is spared by the soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sel_q <= 1'b0;
        else if (hit_cfgb) sel_q <= reg_wdata[SEL_BIT];
    end

    ifc_cfg_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst_req   (srst_req),
        .commit_req (commit_req),
        .soft_rst_o (soft_rst_o),
        .commit_o   (commit)
    );

    ifc_dbuf_reg #(.W(DATA_W)) u_dbuf (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (soft_rst_o),
        .wr_en  (buf_wr),
        .wdata  (reg_wdata),
        .commit (commit),
        .buf_q  (buf_q),
        .act_q  (act_q)
    );

    ifc_rd_mux #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .ADR_CFGA (ADR_CFGA),
        .ADR_CFGB (ADR_CFGB),
        .ADR_UPD  (ADR_UPD),
        .ADR_BUF  (ADR_BUF)
    ) u_rd (
        .reg_addr  (reg_addr),
        .srst_flag (soft_rst_o),
        .sel       (sel_q),
        .commit    (commit),
        .buf_q     (buf_q),
        .act_q     (act_q),
        .rdata     (reg_rdata)
    );
endmodule

// File: rtl/ifc_cfg_bank_chk.sv
module ifc_cfg_bank_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADR_CFGA = 'h0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              soft_rst_o,
    input logic              sel_q,
    input logic              commit,
    input logic [DATA_W-1:0] buf_q,
    input logic [DATA_W-1:0] act_q
);
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    p_pulse_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> $past(reg_wr && (reg_addr == ADR_CFGA) && reg_wdata[7]));

    p_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADR_CFGA) |->
            (reg_rdata[3:0] == {reg_rdata[4], reg_rdata[5], reg_rdata[6], reg_rdata[7]})
            && (reg_rdata[6:4] == 3'b001));

    p_sel_spared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_rst_o && !(reg_wr && reg_addr == 'h0001)) |=> $stable(sel_q));

    p_active_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !soft_rst_o) |=> $stable(act_q));

    p_commit_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (act_q == $past(buf_q)));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> (act_q == '0) && (buf_q == '0) && !commit);
endmodule

bind ifc_cfg_bank ifc_cfg_bank_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADR_CFGA (ADR_CFGA)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .soft_rst_o (soft_rst_o),
    .sel_q      (sel_q),
    .commit     (commit),
    .buf_q      (buf_q),
    .act_q      (act_q)
);

// File: tb/ifc_cfg_bank_tb_top.sv
module ifc_cfg_bank_tb_top;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              soft_rst_o;

    int errors = 0;
    int checks = 0;

    // behavioural model state
    bit       m_srst = 0;
    bit       m_upd  = 0;
    bit       m_sel  = 0;
    bit [7:0] m_buf  = 0;
    bit [7:0] m_act  = 0;

    always #4 clk = ~clk;

    ifc_cfg_bank dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .soft_rst_o (soft_rst_o)
    );

    function automatic bit [7:0] exp_rd(input bit [15:0] a);
        case (a)
            16'h0000: return {m_srst, 3'b001, 3'b100, m_srst};
            16'h0001: return {2'b00, m_sel, 5'b00000};
            16'h000F: return {7'b0, m_upd};
            16'h0100: return m_sel ? m_buf : m_act;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input bit [15:0] a);
        case (a)
            16'h0000: return "R3";
            16'h0001: return "R4";
            16'h000F: return "R10";
            16'h0100: return "R8";
            default:  return "R11";
        endcase
    endfunction

    task automatic compare(input string tag);
        bit [7:0] e;
        e = exp_rd(reg_addr);
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s addr=%h rdata actual=%h expected=%h", tag, reg_addr, reg_rdata, e);
        end
        checks++;
        if (soft_rst_o !== m_srst) begin
            errors++;
            $display("FAIL R2 soft_rst_o actual=%0b expected=%0b", soft_rst_o, m_srst);
        end
    endtask

    task automatic model_edge(input bit wr, input bit [15:0] a, input bit [7:0] d);
        bit n_srst, n_upd;
        n_srst = 0;
        n_upd  = 0;
        if (wr && a == 16'h0001) m_sel = d[5];
        if (m_srst) begin
            m_buf = 0;
            m_act = 0;
        end else begin
            if (m_upd) m_act = m_buf;
            if (wr && a == 16'h0100) m_buf = d;
            if (wr && a == 16'h0000 && d[7]) n_srst = 1;
            else if (wr && a == 16'h000F && d[0]) n_upd = 1;
        end
        m_srst = n_srst;
        m_upd  = n_upd;
    endtask

    task automatic step(input bit wr, input bit [15:0] a, input bit [7:0] d, input string tag);
        @(negedge clk);
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = d;
        #2;
        compare(tag);
        @(posedge clk);
        #1;
        model_edge(wr, a, d);
    endtask

    task automatic rd(input bit [15:0] a, input string tag);
        step(0, a, 8'h00, tag);
    endtask

    task automatic wr(input bit [15:0] a, input bit [7:0] d, input string tag);
        step(1, a, d, tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(16'h0000, "R1");
        rd(16'h0001, "R1");
        rd(16'h000F, "R1");
        rd(16'h0100, "R1");
        // R11 unmapped addresses
        rd(16'h0002, "R11");
        rd(16'h0103, "R11");
        rd(16'h0200, "R11");

        // R4 writable select bit only
        wr(16'h0001, 8'hFF, "R4");
        rd(16'h0001, "R4");
        wr(16'h0001, 8'h00, "R4");
        rd(16'h0001, "R4");

        // R6 buffer write, active unchanged
        wr(16'h0100, 8'hA5, "R6");
        rd(16'h0100, "R6");
        // R8 select buffer copy
        wr(16'h0001, 8'h20, "R8");
        rd(16'h0100, "R8");

        // R7 update strobe
        wr(16'h000F, 8'h01, "R7");
        rd(16'h000F, "R7");
        rd(16'h000F, "R7");
        wr(16'h0001, 8'h00, "R7");
        rd(16'h0100, "R7");

        // R10 update with bit 0 clear does nothing
        wr(16'h0100, 8'h3C, "R10");
        wr(16'h000F, 8'hFE, "R10");
        rd(16'h000F, "R10");
        rd(16'h0100, "R10");

        // R3 read-only bits and mismatched low nibble
        wr(16'h0000, 8'h7E, "R3");
        rd(16'h0000, "R3");
        wr(16'h0000, 8'h01, "R3");
        rd(16'h0000, "R3");

        // R2, R5, R9 soft reset
        wr(16'h0001, 8'h20, "R5");
        wr(16'h0000, 8'h80, "R2");
        rd(16'h0000, "R2");
        rd(16'h0000, "R2");
        rd(16'h0001, "R5");
        rd(16'h0100, "R9");
        wr(16'h0001, 8'h00, "R9");
        rd(16'h0100, "R9");

        // R12 writes discarded in the soft-reset cycle; R5 select write kept
        wr(16'h0100, 8'h5A, "R12");
        wr(16'h0000, 8'h80, "R12");
        wr(16'h0100, 8'h77, "R12");
        wr(16'h0001, 8'h20, "R12");
        rd(16'h0100, "R12");
        wr(16'h0000, 8'h80, "R12");
        wr(16'h000F, 8'h01, "R12");
        rd(16'h000F, "R12");
        wr(16'h0000, 8'h80, "R12");
        wr(16'h0000, 8'h80, "R12");
        rd(16'h0000, "R12");
        rd(16'h0001, "R5");

        // R9 soft reset cancels an update in progress
        wr(16'h0100, 8'hC3, "R9");
        wr(16'h000F, 8'h01, "R9");
        wr(16'h0000, 8'h80, "R9");
        rd(16'h000F, "R9");
        rd(16'h0100, "R9");

        // mixed traffic against the model
        begin
            bit [31:0] lf;
            bit [15:0] addrs [6];
            addrs[0] = 16'h0000; addrs[1] = 16'h0001; addrs[2] = 16'h000F;
            addrs[3] = 16'h0100; addrs[4] = 16'h0100; addrs[5] = 16'h0003;
            lf = 32'h1234_5678;
            for (int i = 0; i < 400; i++) begin
                bit [15:0] a;
                bit [7:0]  d;
                lf = lf * 32'd1664525 + 32'd1013904223;
                a = addrs[lf[26:24] % 6];
                d = lf[15:8];
                if (a == 16'h0000 && lf[20:18] != 0) d[7] = 1'b0;
                step(lf[29], a, d, tag_of(a));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule